// File: doc/BRIEF.md
# Programmable Channel Crossbar Receiver

This block is the receive side of a sixteen-channel parallel bit-stream port. Each cycle of the channel clock carries one bit on every channel plus a once-per-second marker. A clock-enable input marks the cycles on which bits are valid, so the bit-stream rate may equal the channel clock or any binary fraction of it. Only enabled cycles are captured, and both data and marker leave the block two enabled cycles after they arrive, so they stay aligned.

Between capture and output sits a full crossbar. Each internal output channel has its own four-bit source select naming any external channel. A three-bit count code sets how many internal channels are active (1, 2, 4, 8 or 16, always the lowest-numbered ones). Outputs at or above the active count are forced to zero and flagged not valid, so whatever was routed to them is discarded.

Configuration is written into a staging register at any time. A small two-state machine holds it: CFG_STEADY (no change waiting) moves to CFG_WAIT_MARK on a write, and CFG_WAIT_MARK returns to CFG_STEADY on an enabled cycle that carries the marker, at which point the staged settings become active. A write in CFG_WAIT_MARK replaces the staged settings and stays in that state. The mapping therefore changes only at a second boundary, and the sample carrying the marker is the first one routed with the new settings.

Top module: `chan_xbar_rx`

## Requirements
- R1: After reset, dout, vld and pps_out are all zero, and the active configuration is sixteen channels with output i sourced from external channel i.
- R2: When ce is low, din and pps_in are not captured and dout, vld and pps_out hold their values.
- R3: A sample (din and pps_in) presented on an enabled cycle appears on dout and pps_out right after the second enabled clock edge counting that one, and not after the first.
- R4: Output channel i carries external channel sel, where sel is the field cfg_map[4*i+3:4*i] of the active configuration.
- R5: Count codes 0, 1, 2, 3, 4 select 1, 2, 4, 8, 16 active channels, and codes 5 to 7 select 16; vld has exactly the lowest N bits set for N active channels.
- R6: Output channels at or above the active count are driven to zero regardless of the data routed to them.
- R7: A configuration written with cfg_wr is not used until an enabled cycle with pps_in high; the sample presented on that cycle is the first routed with the new settings, and earlier samples use the old ones.
- R8: A second write before the marker replaces the first staged write entirely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Bit-stream enable, marks valid sample cycles |
| pps_in | input | 1 | Once-per-second marker, one enabled cycle wide |
| din | input | 16 | External channel bits |
| cfg_wr | input | 1 | Stage cfg_code and cfg_map this cycle |
| cfg_code | input | 3 | Active channel count code |
| cfg_map | input | 64 | Sixteen 4-bit source selects, field i at bits 4i+3:4i |
| dout | output | 16 | Internal channel bits after crossbar and masking |
| vld | output | 16 | Per internal channel active flag |
| pps_out | output | 1 | Marker aligned with dout |

## Verification
The crossbar is driven with an identity map, a reversing map and a rotate-by-three map, so a swapped field or a wrong field offset shows up as a bit in the wrong position. An all-ones pattern against each count code isolates the masking of inactive outputs from the routing, while an irregular pattern checks routing inside the active range. Gaps with the enable low carrying junk data separate true enable qualification from free-running capture, and a marker placed on a known sample distinguishes a one-stage from a two-stage path. Writes followed by unmarked samples and then a marked one tell apart a configuration applied at write time, one applied one sample late, and one applied on the boundary.

// File: rtl/chxb_pkg.sv
package chxb_pkg;

    typedef enum logic {
        CFG_STEADY,
        CFG_WAIT_MARK
    } cfg_state_t;

endpackage

// File: rtl/chxb_cfg.sv
module chxb_cfg
    import chxb_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int SELW  = 4,
    parameter int CODEW = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ce,
    input  logic                  pps_in,
    input  logic                  cfg_wr,
    input  logic [CODEW-1:0]      cfg_code,
    input  logic [NCH*SELW-1:0]   cfg_map,
    output logic [CODEW-1:0]      act_code,
    output logic [NCH*SELW-1:0]   act_map,
    output logic [NCH-1:0]        act_en
);

    localparam int LOG2N = $clog2(NCH);
    localparam logic [CODEW-1:0] FULL_CODE = CODEW'(LOG2N);

    function automatic logic [NCH*SELW-1:0] ident_map();
        logic [NCH*SELW-1:0] m;
        for (int i = 0; i < NCH; i++) begin
            m[i*SELW +: SELW] = SELW'(i);
        end
        return m;
    endfunction

    cfg_state_t state_q, state_d;
    logic [CODEW-1:0]    stg_code;
    logic [NCH*SELW-1:0] stg_map;
    logic                mark;

    assign mark = ce && pps_in;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CFG_STEADY;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CFG_STEADY:    if (cfg_wr) state_d = CFG_WAIT_MARK;
            CFG_WAIT_MARK: if (cfg_wr) state_d = CFG_WAIT_MARK;
                           else if (mark) state_d = CFG_STEADY;
            default:       state_d = CFG_STEADY;
        endcase
    end

    // staged and active settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_code <= FULL_CODE;
            stg_map  <= ident_map();
            act_code <= FULL_CODE;
            act_map  <= ident_map();
        end else begin
            if (cfg_wr) begin
                stg_code <= cfg_code;
                stg_map  <= cfg_map;
            end
            if (state_q == CFG_WAIT_MARK && mark) begin
                act_code <= stg_code;
                act_map  <= stg_map;
            end
        end
    end

    // active channel mask: lowest N bits
    always_comb begin
        int n;
        if (act_code >= FULL_CODE) n = NCH;
        else                       n = 1 << act_code;
        for (int i = 0; i < NCH; i++) begin
            act_en[i] = (i < n);
        end
    end

endmodule

// File: rtl/chxb_capture.sv
module chxb_capture #(
    parameter int NCH = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ce,
    input  logic           pps_in,
    input  logic [NCH-1:0] din,
    output logic           s1_pps,
    output logic [NCH-1:0] s1_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_pps  <= 1'b0;
            s1_data <= '0;
        end else if (ce) begin
            s1_pps  <= pps_in;
            s1_data <= din;
        end
    end

endmodule

// File: rtl/chxb_xbar.sv
module chxb_xbar #(
    parameter int NCH  = 16,
    parameter int SELW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce,
    input  logic                s1_pps,
    input  logic [NCH-1:0]      s1_data,
    input  logic [NCH*SELW-1:0] act_map,
    input  logic [NCH-1:0]      act_en,
    output logic [NCH-1:0]      dout,
    output logic [NCH-1:0]      vld,
    output logic                pps_out
);

    logic [NCH-1:0] picked;

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        logic [SELW-1:0] sel;
        assign sel       = act_map[g*SELW +: SELW];
        assign picked[g] = s1_data[sel] & act_en[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= '0;
            vld     <= '0;
            pps_out <= 1'b0;
        end else if (ce) begin
            dout    <= picked;
            vld     <= act_en;
            pps_out <= s1_pps;
        end
    end

endmodule

// File: rtl/chan_xbar_rx.sv
module chan_xbar_rx #(
    parameter int NCH   = 16,
    parameter int SELW  = 4,
    parameter int CODEW = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce,
    input  logic                pps_in,
    input  logic [NCH-1:0]      din,
    input  logic                cfg_wr,
    input  logic [CODEW-1:0]    cfg_code,
    input  logic [NCH*SELW-1:0] cfg_map,
    output logic [NCH-1:0]      dout,
    output logic [NCH-1:0]      vld,
    output logic                pps_out
);

    logic [CODEW-1:0]    act_code;
    logic [NCH*SELW-1:0] act_map;
    logic [NCH-1:0]      act_en;
    logic                s1_pps;
    logic [NCH-1:0]      s1_data;

    chxb_cfg #(.NCH(NCH), .SELW(SELW), .CODEW(CODEW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .ce(ce), .pps_in(pps_in),
        .cfg_wr(cfg_wr), .cfg_code(cfg_code), .cfg_map(cfg_map),
        .act_code(act_code), .act_map(act_map), .act_en(act_en)
    );

    chxb_capture #(.NCH(NCH)) u_cap (
        .clk(clk), .rst_n(rst_n), .ce(ce), .pps_in(pps_in), .din(din),
        .s1_pps(s1_pps), .s1_data(s1_data)
    );

    chxb_xbar #(.NCH(NCH), .SELW(SELW)) u_xbar (
        .clk(clk), .rst_n(rst_n), .ce(ce), .s1_pps(s1_pps),
        .s1_data(s1_data), .act_map(act_map), .act_en(act_en),
        .dout(dout), .vld(vld), .pps_out(pps_out)
    );

endmodule

// File: rtl/chxb_chk.sv
module chxb_chk #(
    parameter int NCH   = 16,
    parameter int CODEW = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce,
    input logic             pps_in,
    input logic [NCH-1:0]   dout,
    input logic [NCH-1:0]   vld,
    input logic             pps_out,
    input logic [CODEW-1:0] act_code
);

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> ($stable(dout) && $stable(vld) && $stable(pps_out)));

    // R5
    vld_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vld + NCH'(1)));

    // R6
    inactive_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dout & ~vld) == '0);

    // R7
    cfg_on_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_code) |-> $past(ce && pps_in));

endmodule

bind chan_xbar_rx chxb_chk #(.NCH(NCH), .CODEW(CODEW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ce(ce), .pps_in(pps_in),
    .dout(dout), .vld(vld), .pps_out(pps_out), .act_code(act_code)
);

// File: tb/sim_chan_xbar_rx.sv
module sim_chan_xbar_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b0;
    logic        pps_in = 1'b0;
    logic [15:0] din = '0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_code = '0;
    logic [63:0] cfg_map = '0;
    logic [15:0] dout;
    logic [15:0] vld;
    logic        pps_out;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    chan_xbar_rx u0 (
        .clk(clk), .rst_n(rst_n), .ce(ce), .pps_in(pps_in), .din(din),
        .cfg_wr(cfg_wr), .cfg_code(cfg_code), .cfg_map(cfg_map),
        .dout(dout), .vld(vld), .pps_out(pps_out)
    );

    logic [63:0] m_id, m_rev, m_rot;

    function automatic logic [15:0] route(input logic [15:0] d, input logic [63:0] m);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = d[m[i*4 +: 4]];
        return r;
    endfunction

    function automatic logic [15:0] mask_of(input logic [2:0] code);
        int n;
        n = (code >= 3'd4) ? 16 : (1 << code);
        return 16'((32'd1 << n) - 1);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic e, input logic p, input logic [15:0] d);
        @(negedge clk);
        ce = e; pps_in = p; din = d;
        @(posedge clk);
        #1;
    endtask

    task automatic cfg_write(input logic [2:0] code, input logic [63:0] m);
        @(negedge clk);
        ce = 1'b0; pps_in = 1'b0;
        cfg_wr = 1'b1; cfg_code = code; cfg_map = m;
        @(posedge clk);
        #1;
        cfg_wr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 dout", dout, 16'h0);
        check("R1 vld", vld, 16'h0);
        check("R1 pps_out", {15'd0, pps_out}, 16'h0);
    endtask

    task automatic t_identity();
        step(1, 0, 16'h1234);
        step(1, 0, 16'hBEEF);
        check("R1 R3 default map", dout, 16'h1234);
        check("R1 default vld", vld, 16'hFFFF);
        step(1, 0, 16'h0F0F);
        check("R3 next sample", dout, 16'hBEEF);
    endtask

    task automatic t_hold();
        step(0, 1, 16'hAAAA);
        check("R2 hold dout", dout, 16'hBEEF);
        step(0, 0, 16'h5555);
        check("R2 hold dout 2", dout, 16'hBEEF);
        check("R2 hold pps", {15'd0, pps_out}, 16'h0);
        step(1, 0, 16'h3C3C);
        check("R2 skipped junk", dout, 16'h0F0F);
    endtask

    task automatic t_pps();
        step(1, 1, 16'h7001);
        check("R3 pps not after one edge", {15'd0, pps_out}, 16'h0);
        step(0, 0, 16'hFFFF);
        step(1, 0, 16'h7002);
        check("R3 pps after two edges", {15'd0, pps_out}, 16'h1);
        check("R3 data with pps", dout, 16'h7001);
        step(1, 0, 16'h7003);
        check("R3 pps one wide", {15'd0, pps_out}, 16'h0);
    endtask

    task automatic t_remap();
        cfg_write(3'd4, m_rev);
        step(1, 0, 16'h00F1);
        step(1, 0, 16'h8421);
        check("R7 not yet applied", dout, 16'h00F1);
        step(1, 1, 16'hC001);
        check("R7 pre-mark sample old map", dout, 16'h8421);
        step(1, 0, 16'h0000);
        check("R4 R7 reversed map", dout, route(16'hC001, m_rev));
    endtask

    task automatic t_count();
        logic [2:0] codes [6] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd7};
        foreach (codes[k]) begin
            cfg_write(codes[k], m_rot);
            step(1, 1, 16'hFFFF);
            step(1, 0, 16'hA5C3);
            check("R6 inactive zero", dout, mask_of(codes[k]));
            check("R5 vld", vld, mask_of(codes[k]));
            step(1, 0, 16'h0000);
            check("R4 R5 rotated", dout, route(16'hA5C3, m_rot) & mask_of(codes[k]));
        end
    endtask

    task automatic t_overwrite();
        cfg_write(3'd2, m_rot);
        cfg_write(3'd1, m_rev);
        step(1, 1, 16'h9001);
        step(1, 0, 16'h0000);
        check("R8 code replaced", vld, 16'h0003);
        check("R8 map replaced", dout, route(16'h9001, m_rev) & 16'h0003);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_id[i*4 +: 4]  = 4'(i);
            m_rev[i*4 +: 4] = 4'(15 - i);
            m_rot[i*4 +: 4] = 4'((i + 3) % 16);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_identity();
        t_hold();
        t_pps();
        t_remap();
        t_count();
        t_overwrite();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule